// File: doc/BRIEF.md
# Bus Wait-State and Timeout Generator

This block produces the transfer acknowledge for a handshaked, asynchronous-style processor bus, with a configurable number of wait states for each of two memory regions. One region is RAM and the other is ROM. Each region has an active-low select and its own 2-bit wait code. A small counter per region delays the acknowledge by the coded number of bus clocks after its select goes active. The region acknowledges are merged onto one active-low acknowledge output.

A separate watchdog counts bus clocks while the active-low address strobe is held. If the strobe stays asserted until the count reaches its limit, the block drives an active-low bus error. Everything runs on the bus clock. The processor samples the acknowledge once per clock, and every clock in which the acknowledge is still high counts as one wait state.

Top module: `bus_wait_gen`

## Requirements
- R1: While rst_ni is low, dtack_no and berr_no are both high, whatever the other inputs are.
- R2: While a region's select is high, that region's counter reloads from its wait code on every rising edge. dtack_no stays high while both selects are high.
- R3: The wait code maps 2'b11 to 0 wait states, 2'b10 to 1, 2'b01 to 2 and 2'b00 to 3. With N wait states, dtack_no goes low after the (N+1)-th rising edge at which the select is sampled low.
- R4: The code that counts is the one sampled at the last rising edge with the select high. A change of code while the select is low does not alter the delay.
- R5: The RAM and ROM regions use their own codes independently. The code of the non-selected region has no effect.
- R6: dtack_no returns high after the first rising edge at which the active select is sampled high.
- R7: While as_ni is high, the strobe counter is held at zero. berr_no stays high until the 255th consecutive rising edge with as_ni low. It goes low right after that edge.
- R8: berr_no returns high as soon as as_ni goes high, without waiting for a clock edge. The next low period of as_ni counts again from zero.
- R9: Both selects low at the same time is an illegal input and is flagged by an assertion.
- R10: Once asserted, berr_no stays low for as long as as_ni remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_ni | input | 1 | Address strobe, active low |
| ram_cs_ni | input | 1 | RAM region select, active low |
| rom_cs_ni | input | 1 | ROM region select, active low |
| ram_wait_i | input | 2 | RAM wait code |
| rom_wait_i | input | 2 | ROM wait code |
| dtack_no | output | 1 | Transfer acknowledge, active low |
| berr_no | output | 1 | Bus error, active low |

## Verification
The hardest situation to reach is the boundary of the strobe watchdog. It needs hundreds of uninterrupted clocks of a held strobe, and the edge where the error must appear lies exactly one clock past the point where it must not. The stimulus holds the strobe low with no select active and samples the error output after edges 254 and 255 and well beyond. It then releases the strobe between edges to observe the asynchronous release. A further case holds the strobe low twice for 200 clocks with a short break in between, to show that the count restarts. Random bus cycles change the wait code right after a select asserts, which exercises the rule that the code is sampled at reload.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  localparam int unsigned DEF_CODE_W = 2;
  localparam int unsigned DEF_TO_W   = 8;
  localparam int unsigned NUM_REGION = 2;
endpackage

// File: rtl/bwg_wait_region.sv
module bwg_wait_region #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              ack_o
);
  logic [CODE_W-1:0] cnt_q;
  logic              ack_q;

  // code all-ones means zero waits: remaining wait count is the inverted code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      ack_q <= 1'b0;
    end else if (cs_ni) begin
      cnt_q <= ~code_i;
      ack_q <= 1'b0;
    end else if (cnt_q == '0) begin
      ack_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/bwg_strobe_timeout.sv
module bwg_strobe_timeout #(
  parameter int unsigned          TO_W     = 8,
  parameter logic [TO_W-1:0]      TO_LIMIT = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic expired_o
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (strobe_ni) begin
      cnt_q <= '0;
    end else if (cnt_q != TO_LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // release follows the strobe directly, not the counter clear
  assign expired_o = !strobe_ni && (cnt_q == TO_LIMIT);
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned TO_W   = DEF_TO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_ni,
  input  logic              ram_cs_ni,
  input  logic              rom_cs_ni,
  input  logic [CODE_W-1:0] ram_wait_i,
  input  logic [CODE_W-1:0] rom_wait_i,
  output logic              dtack_no,
  output logic              berr_no
);
  localparam logic [TO_W-1:0] TO_LIMIT = '1;

  logic [NUM_REGION-1:0]             cs_n;
  logic [NUM_REGION-1:0][CODE_W-1:0] codes;
  logic [NUM_REGION-1:0]             ack;
  logic                              expired;

  assign cs_n  = {rom_cs_ni, ram_cs_ni};
  assign codes = {rom_wait_i, ram_wait_i};

  for (genvar g = 0; g < NUM_REGION; g++) begin : g_region
    bwg_wait_region #(.CODE_W(CODE_W)) u_region (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cs_ni  (cs_n[g]),
      .code_i (codes[g]),
      .ack_o  (ack[g])
    );
  end

  bwg_strobe_timeout #(.TO_W(TO_W), .TO_LIMIT(TO_LIMIT)) u_timeout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_ni (as_ni),
    .expired_o (expired)
  );

  assign dtack_no = ~|ack;
  assign berr_no  = ~expired;
endmodule

// File: rtl/bus_wait_gen_chk.sv
module bus_wait_gen_chk #(
  parameter int unsigned CODE_W = 2,
  parameter int unsigned TO_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              as_ni,
  input logic              ram_cs_ni,
  input logic              rom_cs_ni,
  input logic [CODE_W-1:0] ram_wait_i,
  input logic              dtack_no,
  input logic              berr_no
);
  localparam logic [TO_W-1:0] LIM = '1;
  logic [TO_W-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_run <= '0;
    else if (as_ni)           low_run <= '0;
    else if (low_run != LIM)  low_run <= low_run + 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (dtack_no && berr_no); // R1
    end
  end

  AST_CS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_cs_ni && !rom_cs_ni)); // R9
  AST_IDLE_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_cs_ni && rom_cs_ni) |=> dtack_no); // R6
  AST_ACK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtack_no |-> (!$past(ram_cs_ni) || !$past(rom_cs_ni))); // R2
  AST_ZERO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ram_cs_ni) && rom_cs_ni && $past(ram_wait_i) == '1) |=> !dtack_no); // R3
  AST_BERR_NEEDS_AS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !berr_no |-> !as_ni); // R8
  AST_BERR_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_run != LIM) |-> berr_no); // R7
  AST_BERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_run == LIM && !as_ni) |-> !berr_no); // R10
endmodule

bind bus_wait_gen bus_wait_gen_chk #(.CODE_W(CODE_W), .TO_W(TO_W)) chk_i (.*);

// File: tb/bus_wait_gen_tb_top.sv
module bus_wait_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       as_ni = 1'b1;
  logic       ram_cs_ni = 1'b1;
  logic       rom_cs_ni = 1'b1;
  logic [1:0] ram_wait_i = 2'b11;
  logic [1:0] rom_wait_i = 2'b11;
  logic       dtack_no;
  logic       berr_no;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_wait_gen dut_i (.*);

  function automatic int exp_waits(input logic [1:0] code);
    return 3 - int'(code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one bus cycle on a region; optionally flip the code after select asserts
  task automatic bus_cycle(input bit rom, input logic [1:0] code,
                           input logic [1:0] other, input bit flip);
    int edges;
    @(negedge clk_i);
    if (rom) begin rom_wait_i = code; ram_wait_i = other; end
    else     begin ram_wait_i = code; rom_wait_i = other; end
    @(negedge clk_i);
    check(dtack_no == 1'b1, "R2 idle", dtack_no, 1);
    as_ni = 1'b0;
    if (rom) rom_cs_ni = 1'b0; else ram_cs_ni = 1'b0;
    if (flip) begin
      if (rom) rom_wait_i = ~code; else ram_wait_i = ~code;
    end
    edges = 0;
    while (dtack_no && edges < 8) begin
      @(negedge clk_i);
      edges++;
    end
    check(edges - 1 == exp_waits(code), flip ? "R4 code flip" : (rom ? "R5 rom" : "R3 ram"),
          edges - 1, exp_waits(code));
    as_ni = 1'b1;
    ram_cs_ni = 1'b1;
    rom_cs_ni = 1'b1;
    @(negedge clk_i);
    check(dtack_no == 1'b1, "R6 release", dtack_no, 1);
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    // R1: outputs high in reset even with inputs asserted
    as_ni = 1'b0; ram_cs_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(dtack_no && berr_no, "R1 reset", {dtack_no, berr_no}, 3);
    as_ni = 1'b1; ram_cs_ni = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(dtack_no == 1'b1, "R2 after reset", dtack_no, 1);

    // R3/R5: every code on both regions, other region code opposite
    for (int c = 0; c < 4; c++) begin
      bus_cycle(1'b0, 2'(c), ~2'(c), 1'b0);
      bus_cycle(1'b1, 2'(c), ~2'(c), 1'b0);
    end
    // R4: flip code after select asserts
    bus_cycle(1'b0, 2'b11, 2'b00, 1'b1);
    bus_cycle(1'b1, 2'b00, 2'b11, 1'b1);

    // random cycles
    for (int i = 0; i < 40; i++) begin
      bus_cycle(1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
    end

    // R7: strobe watchdog boundary
    @(negedge clk_i);
    as_ni = 1'b0;
    repeat (254) @(negedge clk_i);
    check(berr_no == 1'b1, "R7 edge 254", berr_no, 1);
    @(negedge clk_i);
    check(berr_no == 1'b0, "R7 edge 255", berr_no, 0);
    repeat (40) @(negedge clk_i);
    check(berr_no == 1'b0, "R10 held", berr_no, 0);
    // R8: asynchronous release
    #1 as_ni = 1'b1;
    #1 check(berr_no == 1'b1, "R8 release", berr_no, 1);
    @(negedge clk_i);
    as_ni = 1'b0;
    repeat (10) @(negedge clk_i);
    check(berr_no == 1'b1, "R8 restart", berr_no, 1);
    as_ni = 1'b1;
    @(negedge clk_i);
    // R7: two long low periods with a break never sum up
    as_ni = 1'b0;
    repeat (200) @(negedge clk_i);
    as_ni = 1'b1;
    @(negedge clk_i);
    as_ni = 1'b0;
    repeat (200) @(negedge clk_i);
    check(berr_no == 1'b1, "R7 held zero", berr_no, 1);
    as_ni = 1'b1;
    @(negedge clk_i);
    check(dtack_no && berr_no, "R2 final idle", {dtack_no, berr_no}, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule